// File: doc/BRIEF.md
# Physical Memory Protection Checker with Effective Privilege

This block decides whether one memory access may proceed, given a small table of protection entries. Each request brings a physical byte address, a naturally aligned size of 1, 2, 4 or 8 bytes, an access type, the hart's current privilege, and the two machine status fields that can redirect data accesses to another privilege. The block first works out the privilege that governs the access. It then matches the access against every entry in parallel. The lowest-numbered entry that touches the access decides which rights apply.

Each entry is one configuration byte plus one address word. The address word holds physical address bits [PA_WIDTH-1:2]. The verdict is registered: one cycle after a valid request, the block raises exactly one of an allow flag or a violation flag. A fetch is never redirected by the status fields. A machine-level access is only limited by entries that carry the lock bit.

Top module: `pmp_guard`

## Requirements
- R1: When the hart privilege is M (encoding 3) and the access is a read (type 0) or write (type 1) with `mprv` set, the privilege used for the check is `mpp`. Privilege encodings are U=0, S=1, M=3.
- R2: A fetch (type 2) is always checked at the hart privilege, whatever `mprv` and `mpp` hold. So is any access when `mprv` is clear or the hart is below M.
- R3: If the effective privilege is M and the deciding entry has its lock bit (config bit 7) clear, the access is allowed whatever the entry's permission bits say.
- R4: If the effective privilege is below M, or the deciding entry is locked, the access is allowed only when the requested right is set in the config byte. A read needs R (bit 0), a write needs W (bit 1), and a fetch needs X (bit 2).
- R5: If no entry touches the access, it is allowed at effective privilege M and denied below M.
- R6: When several entries match, the one with the lowest index alone decides.
- R7: Config bits [4:3] select the match mode. 0 is off and never matches. 1 is top-of-range: entry i covers words from address word i-1 (0 for entry 0) up to, but not including, address word i. 2 is a single aligned 4-byte word equal to the address word.
- R8: Match mode 3 is a naturally aligned power-of-two region. With t trailing ones in the address word, the region is 2^(t+3) bytes. The remaining upper bits give its base.
- R9: An access whose bytes are only partly inside the deciding entry is denied, even at effective privilege M.
- R10: `rsp_valid` follows `req_valid` by one cycle. In a response cycle exactly one of `rsp_allow` and `rsp_violation` is high. Otherwise both are low, and all three are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | PA_WIDTH | Physical byte address of the access |
| req_size | input | 2 | log2 of access bytes (0..3), naturally aligned |
| req_type | input | 2 | 0 read, 1 write, 2 fetch |
| hart_priv | input | 2 | Current hart privilege (U=0, S=1, M=3) |
| mprv | input | 1 | Redirect data accesses made in M to `mpp` |
| mpp | input | 2 | Privilege used for redirected data accesses |
| entry_cfg | input | NUM_ENTRIES*8 | Config bytes, entry i in bits [8i+7:8i] |
| entry_addr | input | NUM_ENTRIES*(PA_WIDTH-2) | Address words, entry i in slice i |
| rsp_valid | output | 1 | Registered verdict present |
| rsp_allow | output | 1 | Access permitted |
| rsp_violation | output | 1 | Access refused |

## Verification
The assertions assume that `req_type` never carries the unused code 3, and that `hart_priv` and `mpp` stay within U, S and M. They also assume that the address and size describe a naturally aligned access of at most 8 bytes. Under those conditions, a region of 4-byte granularity that overlaps the access always contains its first or its last byte. The directed tasks drive only those codes and only aligned addresses. They drive the table and privilege inputs one cycle before the response they check, so every property sees a stable, legal request in its triggering cycle.

// File: rtl/pmp_guard_pkg.sv
package pmp_guard_pkg;

   typedef enum logic [1:0] {
      PRIV_U   = 2'd0,
      PRIV_S   = 2'd1,
      PRIV_RSV = 2'd2,
      PRIV_M   = 2'd3
   } priv_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSV   = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      AM_OFF   = 2'd0,
      AM_TOR   = 2'd1,
      AM_NA4   = 2'd2,
      AM_NAPOT = 2'd3
   } amode_e;

   typedef struct packed {
      logic       lock;
      logic [1:0] spare;
      amode_e     amode;
      logic       x;
      logic       w;
      logic       r;
   } cfg_t;

   localparam int unsigned CFG_BITS = $bits(cfg_t);

   function automatic logic [2:0] rights_of(input logic [1:0] t);
      logic [2:0] v;
      case (t)
         ACC_READ:  v = 3'b001;
         ACC_WRITE: v = 3'b010;
         ACC_FETCH: v = 3'b100;
         default:   v = 3'b000;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/pmp_eff_priv.sv
module pmp_eff_priv
   import pmp_guard_pkg::*;
(
   input  logic [1:0] hart_priv,
   input  logic       mprv,
   input  logic [1:0] mpp,
   input  logic [1:0] acc_type,
   output logic [1:0] eff_priv
);
   logic redirect;

   always_comb begin
      redirect = (hart_priv == PRIV_M) && (acc_type != ACC_FETCH) && mprv;
      eff_priv = redirect ? mpp : hart_priv;
   end
endmodule

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
   import pmp_guard_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic [1:0]    amode,
   input  logic [AW-1:0] addr_reg,
   input  logic [AW-1:0] lo_bound,
   input  logic [AW-1:0] first_w,
   input  logic [AW-1:0] last_w,
   output logic          hit_first,
   output logic          hit_last
);
   logic [AW-1:0] ones;
   logic [AW-1:0] keep;

   always_comb begin
      ones = addr_reg ^ (addr_reg + {{(AW-1){1'b0}}, 1'b1});
      keep = ~ones;
      hit_first = 1'b0;
      hit_last  = 1'b0;
      case (amode)
         AM_TOR: begin
            hit_first = (first_w >= lo_bound) && (first_w < addr_reg);
            hit_last  = (last_w  >= lo_bound) && (last_w  < addr_reg);
         end
         AM_NA4: begin
            hit_first = (first_w == addr_reg);
            hit_last  = (last_w  == addr_reg);
         end
         AM_NAPOT: begin
            hit_first = ((first_w ^ addr_reg) & keep) == '0;
            hit_last  = ((last_w  ^ addr_reg) & keep) == '0;
         end
         default: begin
            hit_first = 1'b0;
            hit_last  = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/pmp_rights_sel.sv
module pmp_rights_sel
   import pmp_guard_pkg::*;
#(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0]   hit_first,
   input  logic [N-1:0]   hit_last,
   input  logic [N-1:0]   lock,
   input  logic [3*N-1:0] rwx,
   input  logic [1:0]     eff_priv,
   input  logic [2:0]     want,
   output logic           allow,
   output logic           any_hit
);
   logic       done;
   logic [2:0] grant;

   always_comb begin
      allow   = (eff_priv == PRIV_M);
      any_hit = 1'b0;
      done    = 1'b0;
      grant   = 3'b000;
      for (int i = 0; i < int'(N); i++) begin
         if (!done && (hit_first[i] || hit_last[i])) begin
            done    = 1'b1;
            any_hit = 1'b1;
            if (hit_first[i] && hit_last[i]) begin
               grant = ((eff_priv == PRIV_M) && !lock[i]) ? 3'b111 : rwx[3*i +: 3];
               allow = |(grant & want);
            end else begin
               allow = 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
   import pmp_guard_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 4,
   parameter int unsigned PA_WIDTH    = 34
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                req_valid,
   input  logic [PA_WIDTH-1:0]                 req_addr,
   input  logic [1:0]                          req_size,
   input  logic [1:0]                          req_type,
   input  logic [1:0]                          hart_priv,
   input  logic                                mprv,
   input  logic [1:0]                          mpp,
   input  logic [NUM_ENTRIES*8-1:0]            entry_cfg,
   input  logic [NUM_ENTRIES*(PA_WIDTH-2)-1:0] entry_addr,
   output logic                                rsp_valid,
   output logic                                rsp_allow,
   output logic                                rsp_violation
);
   localparam int unsigned AW = PA_WIDTH - 2;

   if (NUM_ENTRIES < 1 || NUM_ENTRIES > 16) begin : g_bad_entries
      $error("pmp_guard: NUM_ENTRIES must lie in 1..16");
   end
   if (PA_WIDTH < 12 || PA_WIDTH > 64) begin : g_bad_width
      $error("pmp_guard: PA_WIDTH must lie in 12..64");
   end
   if (CFG_BITS != 8) begin : g_bad_cfg
      $error("pmp_guard: config record must be one byte");
   end

   logic [1:0]            eff_priv;
   logic [PA_WIDTH-1:0]   span;
   logic [PA_WIDTH-1:0]   last_b;
   logic [AW-1:0]         first_w;
   logic [AW-1:0]         last_w;
   logic [NUM_ENTRIES-1:0]   hit_first;
   logic [NUM_ENTRIES-1:0]   hit_last;
   logic [NUM_ENTRIES-1:0]   lock;
   logic [3*NUM_ENTRIES-1:0] rwx;
   logic [2*NUM_ENTRIES-1:0] unused_spare;
   logic                  allow;
   logic                  any_hit;

   pmp_eff_priv u_eff (
      .hart_priv (hart_priv),
      .mprv      (mprv),
      .mpp       (mpp),
      .acc_type  (req_type),
      .eff_priv  (eff_priv)
   );

   always_comb begin
      span = '0;
      case (req_size)
         2'd0:    span[2:0] = 3'd0;
         2'd1:    span[2:0] = 3'd1;
         2'd2:    span[2:0] = 3'd3;
         default: span[2:0] = 3'd7;
      endcase
      last_b  = req_addr + span;
      first_w = req_addr[PA_WIDTH-1:2];
      last_w  = last_b[PA_WIDTH-1:2];
   end

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
      cfg_t          cfg;
      logic [AW-1:0] lo;

      assign cfg = cfg_t'(entry_cfg[8*i +: 8]);

      if (i == 0) begin : g_lo_zero
         assign lo = '0;
      end else begin : g_lo_prev
         assign lo = entry_addr[AW*(i-1) +: AW];
      end

      assign lock[i]                = cfg.lock;
      assign rwx[3*i +: 3]          = {cfg.x, cfg.w, cfg.r};
      assign unused_spare[2*i +: 2] = cfg.spare;

      pmp_entry_match #(.AW(AW)) u_match (
         .amode     (cfg.amode),
         .addr_reg  (entry_addr[AW*i +: AW]),
         .lo_bound  (lo),
         .first_w   (first_w),
         .last_w    (last_w),
         .hit_first (hit_first[i]),
         .hit_last  (hit_last[i])
      );
   end

   pmp_rights_sel #(.N(NUM_ENTRIES)) u_sel (
      .hit_first (hit_first),
      .hit_last  (hit_last),
      .lock      (lock),
      .rwx       (rwx),
      .eff_priv  (eff_priv),
      .want      (rights_of(req_type)),
      .allow     (allow),
      .any_hit   (any_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_allow     <= 1'b0;
         rsp_violation <= 1'b0;
      end else begin
         rsp_valid     <= req_valid;
         rsp_allow     <= req_valid & allow;
         rsp_violation <= req_valid & ~allow;
      end
   end
endmodule

// File: rtl/pmp_guard_chk.sv
module pmp_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [1:0] req_type,
   input logic [1:0] hart_priv,
   input logic       mprv,
   input logic [1:0] mpp,
   input logic [1:0] eff_priv,
   input logic       any_hit,
   input logic       rsp_valid,
   input logic       rsp_allow,
   input logic       rsp_violation
);
   AST_MPRV_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && hart_priv == 2'd3 && req_type != 2'd2 && mprv) |-> (eff_priv == mpp)); // R1

   AST_RAW_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_type == 2'd2 || hart_priv != 2'd3 || !mprv)) |-> (eff_priv == hart_priv)); // R2

   AST_NOHIT_MACHINE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !any_hit && eff_priv == 2'd3) |=> rsp_allow); // R5

   AST_NOHIT_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !any_hit && eff_priv != 2'd3) |=> rsp_violation); // R5

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_allow && !rsp_violation)); // R10

   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_allow, rsp_violation}) == 1); // R10
endmodule

bind pmp_guard pmp_guard_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_type      (req_type),
   .hart_priv     (hart_priv),
   .mprv          (mprv),
   .mpp           (mpp),
   .eff_priv      (eff_priv),
   .any_hit       (any_hit),
   .rsp_valid     (rsp_valid),
   .rsp_allow     (rsp_allow),
   .rsp_violation (rsp_violation)
);

// File: tb/pmp_guard_tb.sv
module pmp_guard_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N   = 4;
   localparam int PAW = 34;
   localparam int AW  = PAW - 2;

   localparam logic [1:0] TR = 2'd0, TW = 2'd1, TF = 2'd2;
   localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;
   localparam logic [1:0] A_OFF = 2'd0, A_TOR = 2'd1, A_NA4 = 2'd2, A_NAPOT = 2'd3;

   logic clk = 1'b0;
   logic rst_n;
   logic req_valid;
   logic [PAW-1:0] req_addr;
   logic [1:0] req_size, req_type, hart_priv, mpp;
   logic mprv;
   logic [N*8-1:0] entry_cfg;
   logic [N*AW-1:0] entry_addr;
   logic rsp_valid, rsp_allow, rsp_violation;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmp_guard #(.NUM_ENTRIES(N), .PA_WIDTH(PAW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_type(req_type), .hart_priv(hart_priv),
      .mprv(mprv), .mpp(mpp), .entry_cfg(entry_cfg), .entry_addr(entry_addr),
      .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_violation(rsp_violation)
   );

   function automatic logic [7:0] mk_cfg(input bit l, input logic [1:0] a,
                                         input bit x, input bit w, input bit r);
      return {l, 2'b00, a, x, w, r};
   endfunction

   function automatic logic [AW-1:0] napot(input logic [PAW-1:0] base, input logic [PAW-1:0] size);
      logic [PAW-1:0] v;
      v = (base >> 2) | ((size >> 3) - 1);
      return v[AW-1:0];
   endfunction

   function automatic logic [AW-1:0] word(input logic [PAW-1:0] a);
      return a[PAW-1:2];
   endfunction

   task automatic check3(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: {valid,allow,violation} actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic clear_entries();
      entry_cfg  = '0;
      entry_addr = '0;
   endtask

   task automatic set_entry(input int i, input logic [7:0] c, input logic [AW-1:0] a);
      entry_cfg[i*8 +: 8]   = c;
      entry_addr[i*AW +: AW] = a;
   endtask

   task automatic do_req(input string req, input logic [PAW-1:0] addr, input logic [1:0] sz,
                         input logic [1:0] t, input logic [1:0] pr, input logic mp,
                         input logic [1:0] pp, input logic exp_allow);
      @(negedge clk);
      req_valid = 1'b1; req_addr = addr; req_size = sz; req_type = t;
      hart_priv = pr; mprv = mp; mpp = pp;
      @(posedge clk);
      #1;
      check3(req, {rsp_valid, rsp_allow, rsp_violation}, {1'b1, exp_allow, ~exp_allow});
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      check3("R10 reset", {rsp_valid, rsp_allow, rsp_violation}, 3'b000);
   endtask

   task automatic t_mprv();
      clear_entries();
      set_entry(0, mk_cfg(0, A_NA4, 0, 0, 1), word(34'h1000));
      do_req("R1 mprv to S write",  34'h1000, 2'd2, TW, PM, 1, PS, 1'b0);
      do_req("R2 mprv clear write", 34'h1000, 2'd2, TW, PM, 0, PS, 1'b1);
      do_req("R1 mprv to M write",  34'h1000, 2'd2, TW, PM, 1, PM, 1'b1);
      do_req("R1 mprv to U read",   34'h1000, 2'd2, TR, PM, 1, PU, 1'b1);
      do_req("R2 fetch ignores mprv", 34'h1000, 2'd2, TF, PM, 1, PU, 1'b1);
      do_req("R2 user fetch",       34'h1000, 2'd2, TF, PU, 1, PM, 1'b0);
      do_req("R3 M unlocked fetch", 34'h1000, 2'd2, TF, PM, 0, PU, 1'b1);
   endtask

   task automatic t_lock();
      clear_entries();
      set_entry(0, mk_cfg(1, A_NA4, 0, 0, 1), word(34'h1000));
      do_req("R4 locked M read",  34'h1000, 2'd2, TR, PM, 0, PU, 1'b1);
      do_req("R4 locked M write", 34'h1000, 2'd2, TW, PM, 0, PU, 1'b0);
      do_req("R4 locked M fetch", 34'h1000, 2'd2, TF, PM, 0, PU, 1'b0);
      set_entry(0, mk_cfg(0, A_NA4, 1, 0, 0), word(34'h1000));
      do_req("R4 S fetch with X", 34'h1000, 2'd2, TF, PS, 0, PU, 1'b1);
      do_req("R4 S read no R",    34'h1000, 2'd2, TR, PS, 0, PU, 1'b0);
   endtask

   task automatic t_nomatch();
      clear_entries();
      set_entry(0, mk_cfg(0, A_NA4, 1, 1, 1), word(34'h1000));
      do_req("R5 M no match",        34'h8000, 2'd2, TR, PM, 0, PU, 1'b1);
      do_req("R5 S no match",        34'h8000, 2'd2, TR, PS, 0, PU, 1'b0);
      do_req("R5 M via mprv to S",   34'h8000, 2'd2, TR, PM, 1, PS, 1'b0);
   endtask

   task automatic t_prio();
      clear_entries();
      set_entry(0, mk_cfg(0, A_NAPOT, 0, 0, 1), napot(34'h2000, 34'h100));
      set_entry(1, mk_cfg(0, A_NAPOT, 0, 1, 1), napot(34'h2000, 34'h1000));
      do_req("R6 lower index wins", 34'h2010, 2'd2, TW, PS, 0, PU, 1'b0);
      do_req("R6 second entry",     34'h2200, 2'd2, TW, PS, 0, PU, 1'b1);
   endtask

   task automatic t_modes();
      clear_entries();
      set_entry(0, mk_cfg(0, A_OFF, 0, 0, 0), word(34'h3000));
      set_entry(1, mk_cfg(0, A_TOR, 0, 1, 1), word(34'h3100));
      do_req("R7 tor low edge",   34'h3000, 2'd2, TR, PS, 0, PU, 1'b1);
      do_req("R7 tor top word",   34'h30FC, 2'd2, TR, PS, 0, PU, 1'b1);
      do_req("R7 tor upper excl", 34'h3100, 2'd2, TR, PS, 0, PU, 1'b0);
      do_req("R7 tor below",      34'h2FFC, 2'd2, TR, PS, 0, PU, 1'b0);
      clear_entries();
      set_entry(0, mk_cfg(0, A_TOR, 0, 0, 1), word(34'h40));
      do_req("R7 tor entry0 from zero", 34'h0,  2'd2, TR, PS, 0, PU, 1'b1);
      do_req("R7 tor entry0 last",      34'h3C, 2'd2, TR, PS, 0, PU, 1'b1);
      do_req("R7 tor entry0 excl",      34'h40, 2'd2, TR, PS, 0, PU, 1'b0);
      clear_entries();
      set_entry(0, mk_cfg(0, A_OFF, 1, 1, 1), word(34'h5000));
      do_req("R7 off entry S",    34'h5000, 2'd2, TR, PS, 0, PU, 1'b0);
      do_req("R7 off entry M",    34'h5000, 2'd2, TR, PM, 0, PU, 1'b1);
   endtask

   task automatic t_napot();
      clear_entries();
      set_entry(0, mk_cfg(0, A_NAPOT, 0, 0, 1), napot(34'h4000, 34'h40));
      do_req("R8 napot last word", 34'h403C, 2'd2, TR, PS, 0, PU, 1'b1);
      do_req("R8 napot above",     34'h4040, 2'd2, TR, PS, 0, PU, 1'b0);
      do_req("R8 napot below",     34'h3FFC, 2'd2, TR, PS, 0, PU, 1'b0);
      set_entry(0, mk_cfg(0, A_NAPOT, 0, 0, 1), napot(34'h6000, 34'h8));
      do_req("R8 napot8 inside",   34'h6004, 2'd2, TR, PS, 0, PU, 1'b1);
      do_req("R8 napot8 outside",  34'h6008, 2'd2, TR, PS, 0, PU, 1'b0);
   endtask

   task automatic t_partial();
      clear_entries();
      set_entry(0, mk_cfg(0, A_NA4, 1, 1, 1), word(34'h7004));
      do_req("R9 partial M denied", 34'h7000, 2'd3, TR, PM, 0, PU, 1'b0);
      do_req("R9 full S allowed",   34'h7004, 2'd2, TR, PS, 0, PU, 1'b1);
      do_req("R9 byte S allowed",   34'h7005, 2'd0, TR, PS, 0, PU, 1'b1);
      do_req("R9 adjacent M",       34'h7000, 2'd2, TR, PM, 0, PU, 1'b1);
   endtask

   task automatic t_timing();
      clear_entries();
      do_req("R10 response", 34'h100, 2'd2, TR, PM, 0, PU, 1'b1);
      @(posedge clk);
      #1;
      check3("R10 idle after", {rsp_valid, rsp_allow, rsp_violation}, 3'b000);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_type = '0;
      hart_priv = PM; mprv = 1'b0; mpp = PU;
      clear_entries();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mprv();
      t_lock();
      t_nomatch();
      t_prio();
      t_modes();
      t_napot();
      t_partial();
      t_timing();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule